// File: doc/BRIEF.md
# Single-Channel Block-Copy DMA Engine

The block moves a block of words without the processor touching the data. Software writes a memory base address, a second base address, a word count and a control word that picks the path and the bus discipline and starts the job. The engine then asks an arbiter for the system bus. For each word it reads from the source and writes the value to the destination. When the last word is written it raises an interrupt, which stays high until software clears it.

There are three paths: device to memory, memory to device, and memory to memory. In the memory-to-memory path the second address register names a memory destination. There are two ways to use the bus. Burst mode keeps the bus request up for the whole block. Cycle-stealing mode gives the bus back after every word and asks for it again, so other masters can use the bus between words.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, every register readback (offsets 0 to 4) is zero, and bus_req_o and irq_o are low.
- R2: No bus request is made until software writes the control register (offset 3) with bit 0 set while the engine is idle. That write takes bits [2:1] as the path (00 device to memory, 01 memory to device, 1x memory to memory) and bit 3 as the discipline (1 burst, 0 cycle stealing).
- R3: Word k of the block is read from source base + k and written to destination base + k. Addresses wrap at the address width. The value written equals the value read. The source and destination bases are: the offset-1 register (device space) and the offset-0 register (memory) for device to memory; offsets 0 and 1 for memory to device; offset 0 and offset 1 (both memory space) for memory to memory.
- R4: Read or write commands are issued only while the bus is granted. Each command holds its address and direction stable until the ack.
- R5: In burst mode bus_req_o rises exactly once per non-empty block and stays high until the last write is acknowledged.
- R6: In cycle-stealing mode bus_req_o falls after every word's write ack and rises again for the next word, so it rises exactly once per word.
- R7: A start with a length of zero sets the interrupt in the next cycle and never requests the bus.
- R8: Status (offset 4) reads busy in bit 0, from the start until the last word completes, and the interrupt in bit 1. The interrupt stays set until software writes status with bit 1 set.
- R9: While busy, writes to offsets 0, 1, 2 and 3 are ignored. This includes a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 3 | register offset |
| reg_wdata_i | input | DW | register write data |
| reg_rdata_o | output | DW | register read data for reg_addr_i |
| bus_req_o | output | 1 | bus request to arbiter |
| bus_gnt_i | input | 1 | bus grant from arbiter |
| bus_cmd_valid_o | output | 1 | bus command valid |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_space_o | output | 1 | 1 device space, 0 memory space |
| bus_addr_o | output | AW | word address |
| bus_wdata_o | output | DW | write data |
| bus_rdata_i | input | DW | read data, valid with ack |
| bus_ack_i | input | 1 | command complete |
| irq_o | output | 1 | block-complete interrupt |

## Verification
The hardest situation to reach is a register access that lands in the middle of a transfer. That covers the lock on the configuration, a second start while busy, and the release-then-reacquire gap in cycle-stealing mode. The bench gets there by slowing the bus: the responder adds an extra wait cycle and the arbiter delays grants. Several cycles after the start, it writes new addresses, a new length and a new start, then reads the registers back. The block is then checked to complete with its original length and bases. A sweep over every path, both disciplines and lengths 0 to 4 counts request rises per block and checks both memory images against values computed in the bench. A run whose addresses wrap past the top of the address space is included.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] OFS_MEM  = 3'd0;
  localparam logic [2:0] OFS_AUX  = 3'd1;
  localparam logic [2:0] OFS_LEN  = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  localparam logic [1:0] PATH_DEV2MEM = 2'b00;
  localparam logic [1:0] PATH_MEM2DEV = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_REL
  } dma_state_e;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + AW'(1);
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  output logic [AW-1:0] cfg_mem_o,
  output logic [AW-1:0] cfg_aux_o,
  output logic [LW-1:0] cfg_len_o,
  output logic          start_o,
  output logic [1:0]    start_path_o,
  output logic          start_burst_o,
  output logic          irq_o
);
  logic [AW-1:0] mem_q, aux_q;
  logic [LW-1:0] len_q;
  logic [2:0]    mode_q;
  logic          irq_q;
  logic          cfg_we, irq_clr;

  assign cfg_we        = reg_we_i && !busy_i;
  assign start_o       = cfg_we && reg_addr_i == OFS_CTRL && reg_wdata_i[0];
  assign start_path_o  = reg_wdata_i[2:1];
  assign start_burst_o = reg_wdata_i[3];
  assign irq_clr       = reg_we_i && reg_addr_i == OFS_STAT && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      aux_q  <= '0;
      len_q  <= '0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_we && reg_addr_i == OFS_MEM) mem_q <= reg_wdata_i[AW-1:0];
      if (cfg_we && reg_addr_i == OFS_AUX) aux_q <= reg_wdata_i[AW-1:0];
      if (cfg_we && reg_addr_i == OFS_LEN) len_q <= reg_wdata_i[LW-1:0];
      if (start_o) mode_q <= reg_wdata_i[3:1];
      // completion wins over a clear in the same cycle
      if (done_i)       irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_MEM:  reg_rdata_o = DW'(mem_q);
      OFS_AUX:  reg_rdata_o = DW'(aux_q);
      OFS_LEN:  reg_rdata_o = DW'(len_q);
      OFS_CTRL: reg_rdata_o = DW'({mode_q, 1'b0});
      OFS_STAT: reg_rdata_o = DW'({irq_q, busy_i});
      default:  reg_rdata_o = '0;
    endcase
  end

  assign cfg_mem_o = mem_q;
  assign cfg_aux_o = aux_q;
  assign cfg_len_o = len_q;
  assign irq_o     = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !irq_clr |=> irq_q); // R8
  AST_DONE_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_q); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && reg_we_i |=> $stable(mem_q) && $stable(aux_q) && $stable(len_q)); // R9
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    start_path_i,
  input  logic          start_burst_i,
  input  logic [AW-1:0] cfg_mem_i,
  input  logic [AW-1:0] cfg_aux_i,
  input  logic [LW-1:0] cfg_len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_cmd_valid_o,
  output logic          bus_we_o,
  output logic          bus_space_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i
);
  localparam int NPTR = 2; // 0 source, 1 destination

  dma_state_e state_q, state_d;
  logic [LW-1:0] rem_q;
  logic          burst_q;
  logic [NPTR-1:0] dev_q;
  logic [DW-1:0] data_q;
  logic [NPTR-1:0][AW-1:0] ptr_load, ptr;
  logic [NPTR-1:0] ptr_inc;
  logic go, rd_done, wr_done, last_word;

  assign go        = start_i && cfg_len_i != '0;
  assign rd_done   = state_q == ST_RD && bus_ack_i;
  assign wr_done   = state_q == ST_WR && bus_ack_i;
  assign last_word = rem_q == LW'(1);

  assign ptr_load[0] = (start_path_i == PATH_DEV2MEM) ? cfg_aux_i : cfg_mem_i;
  assign ptr_load[1] = (start_path_i == PATH_DEV2MEM) ? cfg_mem_i : cfg_aux_i;
  assign ptr_inc     = {wr_done, rd_done};

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_ptr #(.AW(AW)) u_ptr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (go),
      .load_val_i (ptr_load[g]),
      .inc_i      (ptr_inc[g]),
      .ptr_o      (ptr[g])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go)         state_d = ST_REQ;
      ST_REQ:  if (bus_gnt_i)  state_d = ST_RD;
      ST_RD:   if (bus_ack_i)  state_d = ST_WR;
      ST_WR:   if (bus_ack_i)  state_d = last_word ? ST_IDLE : (burst_q ? ST_RD : ST_REL);
      ST_REL:  if (!bus_gnt_i) state_d = ST_REQ; // wait for the arbiter to see the release
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      burst_q <= 1'b0;
      dev_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (go) begin
        rem_q   <= cfg_len_i;
        burst_q <= start_burst_i;
        dev_q   <= {start_path_i == PATH_MEM2DEV, start_path_i == PATH_DEV2MEM};
      end else if (wr_done) begin
        rem_q <= rem_q - LW'(1);
      end
      if (rd_done) data_q <= bus_rdata_i;
    end
  end

  assign busy_o          = state_q != ST_IDLE;
  assign done_o          = (wr_done && last_word) || (start_i && cfg_len_i == '0);
  assign bus_req_o       = state_q inside {ST_REQ, ST_RD, ST_WR};
  assign bus_cmd_valid_o = state_q inside {ST_RD, ST_WR};
  assign bus_we_o        = state_q == ST_WR;
  assign bus_addr_o      = bus_we_o ? ptr[1] : ptr[0];
  assign bus_space_o     = bus_we_o ? dev_q[1] : dev_q[0];
  assign bus_wdata_o     = data_q;

  AST_CMD_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cmd_valid_o |-> bus_req_o && bus_gnt_i); // R4
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cmd_valid_o && !bus_ack_i |=>
      bus_cmd_valid_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_space_o)); // R4
  AST_REM_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done && !last_word |=> rem_q == $past(rem_q) - LW'(1)); // R3
  AST_BURST_KEEPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done && !last_word && burst_q |=> bus_req_o); // R5
  AST_STEAL_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done && !burst_q |=> !bus_req_o); // R6
  AST_ZERO_LEN_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cfg_len_i == '0 && !busy_o |=> !bus_req_o && !busy_o); // R7
endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_cmd_valid_o,
  output logic          bus_we_o,
  output logic          bus_space_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          irq_o
);
  logic [AW-1:0] cfg_mem, cfg_aux;
  logic [LW-1:0] cfg_len;
  logic          start, start_burst, busy, done;
  logic [1:0]    start_path;

  dma_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .busy_i        (busy),
    .done_i        (done),
    .cfg_mem_o     (cfg_mem),
    .cfg_aux_o     (cfg_aux),
    .cfg_len_o     (cfg_len),
    .start_o       (start),
    .start_path_o  (start_path),
    .start_burst_o (start_burst),
    .irq_o         (irq_o)
  );

  dma_engine #(.AW(AW), .DW(DW), .LW(LW)) u_engine (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start),
    .start_path_i    (start_path),
    .start_burst_i   (start_burst),
    .cfg_mem_i       (cfg_mem),
    .cfg_aux_i       (cfg_aux),
    .cfg_len_i       (cfg_len),
    .busy_o          (busy),
    .done_o          (done),
    .bus_req_o       (bus_req_o),
    .bus_gnt_i       (bus_gnt_i),
    .bus_cmd_valid_o (bus_cmd_valid_o),
    .bus_we_o        (bus_we_o),
    .bus_space_o     (bus_space_o),
    .bus_addr_o      (bus_addr_o),
    .bus_wdata_o     (bus_wdata_o),
    .bus_rdata_i     (bus_rdata_i),
    .bus_ack_i       (bus_ack_i)
  );
endmodule

// File: tb/sim_dma_steal_ctrl.sv
module sim_dma_steal_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_req, bus_cmd_valid, bus_we, bus_space, irq;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        gnt = 1'b0, ack = 1'b0;
  logic [15:0] rdata = '0;

  dma_steal_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(gnt),
    .bus_cmd_valid_o(bus_cmd_valid), .bus_we_o(bus_we), .bus_space_o(bus_space),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(rdata), .bus_ack_i(ack),
    .irq_o(irq)
  );

  int checks = 0, fails = 0;
  int rises = 0, viol = 0, lat = 0, gdly = 0, lcnt = 0, gcnt = 0;
  logic req_prev = 1'b0;
  logic [15:0] mem_m [256];
  logic [15:0] dev_m [256];
  logic [15:0] exp_mem [256];
  logic [15:0] exp_dev [256];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // arbiter, bus responder and monitors, all on the falling edge
  always @(negedge clk) begin
    if (bus_cmd_valid && !gnt) viol++;
    if (bus_req && !req_prev) rises++;
    req_prev = bus_req;
    if (!bus_req) begin gnt = 1'b0; gcnt = 0; end
    else if (!gnt) begin
      if (gcnt >= gdly) gnt = 1'b1; else gcnt++;
    end
    if (ack) ack = 1'b0;
    else if (bus_cmd_valid) begin
      if (lcnt >= lat) begin
        lcnt = 0;
        ack = 1'b1;
        if (bus_we) begin
          if (bus_space) dev_m[bus_addr] = bus_wdata; else mem_m[bus_addr] = bus_wdata;
        end else begin
          rdata = bus_space ? dev_m[bus_addr] : mem_m[bus_addr];
        end
      end else lcnt++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_xfer(input int path, input int burst, input logic [7:0] mb,
                          input logic [7:0] ab, input int len, input bit poke);
    logic [15:0] v;
    int mis, waited;
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = 16'h1000 + 16'(i * 3);
      dev_m[i] = 16'hD000 + 16'(i);
      exp_mem[i] = mem_m[i];
      exp_dev[i] = dev_m[i];
    end
    for (int k = 0; k < len; k++) begin
      if (path == 0)      exp_mem[8'(mb + k)] = dev_m[8'(ab + k)];
      else if (path == 1) exp_dev[8'(ab + k)] = mem_m[8'(mb + k)];
      else                exp_mem[8'(ab + k)] = mem_m[8'(mb + k)];
    end
    rises = 0; viol = 0;
    wr(3'd0, 16'(mb));
    wr(3'd1, 16'(ab));
    wr(3'd2, 16'(len));
    chk(!bus_req && rises == 0, "R2", "request before start", rises, 0);
    wr(3'd3, 16'((burst << 3) | (path << 1) | 1));
    rd(3'd4, v);
    if (len == 0) chk(v[1:0] == 2'b10, "R7", "status after empty start", int'(v[1:0]), 2);
    else          chk(v[0] == 1'b1, "R8", "busy after start", int'(v[0]), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      wr(3'd0, 16'h00AA);
      wr(3'd1, 16'h00BB);
      wr(3'd2, 16'd2);
      wr(3'd3, 16'h0005);
      rd(3'd0, v); chk(v == 16'(mb), "R9", "mem base write while busy", int'(v), int'(mb));
      rd(3'd1, v); chk(v == 16'(ab), "R9", "aux base write while busy", int'(v), int'(ab));
      rd(3'd2, v); chk(v == 16'(len), "R9", "length write while busy", int'(v), len);
    end
    waited = 0;
    while (!irq && waited < 500) begin @(negedge clk); waited++; end
    chk(irq == 1'b1, "R8", "irq at block end", int'(irq), 1);
    rd(3'd4, v);
    chk(v[1:0] == 2'b10, "R8", "status at end", int'(v[1:0]), 2);
    mis = 0;
    for (int i = 0; i < 256; i++) begin
      if (mem_m[i] !== exp_mem[i]) mis++;
      if (dev_m[i] !== exp_dev[i]) mis++;
    end
    chk(mis == 0, "R3", "words mismatched", mis, 0);
    chk(viol == 0, "R4", "commands without grant", viol, 0);
    if (len == 0)        chk(rises == 0, "R7", "request rises empty block", rises, 0);
    else if (burst != 0) chk(rises == 1, "R5", "request rises burst", rises, 1);
    else                 chk(rises == len, "R6", "request rises stealing", rises, len);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R8", "irq held", int'(irq), 1);
    wr(3'd4, 16'h0002);
    chk(irq == 1'b0, "R8", "irq after clear", int'(irq), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 16'd0, "R1", "register after reset", int'(v), 0);
    end
    chk(!bus_req && !irq, "R1", "req/irq after reset", int'({bus_req, irq}), 0);
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 5; l++) begin
          lat = l % 2;
          gdly = p;
          run_xfer(p, b, 8'(16 + l), 8'(64 + 2 * l), l, 1'b0);
        end
    // writes and restart while busy, slow bus
    lat = 1; gdly = 2;
    run_xfer(1, 0, 8'd200, 8'd100, 6, 1'b1);
    lat = 1; gdly = 1;
    run_xfer(0, 1, 8'd30, 8'd40, 5, 1'b1);
    // address wrap at the top of the space
    lat = 0; gdly = 0;
    run_xfer(2, 1, 8'd254, 8'd120, 4, 1'b0);
    run_xfer(0, 0, 8'd253, 8'd255, 3, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule